// File: doc/BRIEF.md
# Two-Stage Address Translation Dispatcher

This block sits in front of two table walkers in a memory management unit. For each access it decides whether the address needs no translation, one stage, or both stages. The first stage maps an effective address to a guest real address. The second stage maps a guest real address to a host real address. The block starts the walkers in order, feeds the first stage's output into the second, and merges the two results into one response.

The choice of stages depends on three things: the hypervisor-state bit, the relocation bit and the address quadrant. A nonzero partition ID also brings in the second stage. When both stages run, the reported page size is the smaller of the two, and the permission set is what both stages allow.

The block handles one request at a time. A walker fault ends the request at once and is passed through as a flag.

Top module: `xlate_mode_dispatch`

## Requirements
- R1: With `req_hv`=1 and `req_reloc`=0, no walker is started and the response carries `rsp_raddr` equal to `req_addr`, `rsp_psize` all ones, `rsp_perm`=3'b111 and `rsp_fault`=0.
- R2: With `req_hv`=1, `req_reloc`=1, `req_quad` 0 or 3 and `req_lpid`=0, only stage 1 is started, with `req_addr`. The response repeats the stage 1 address, page size and permissions.
- R3: With `req_hv`=0 and `req_reloc`=0, only stage 2 is started, with `req_addr` as its input. The response repeats the stage 2 results.
- R4: With `req_hv`=0 and `req_reloc`=1, stage 1 runs first. Stage 2 then starts with the stage 1 output address, and the response address is the stage 2 output.
- R5: With `req_hv`=1, `req_reloc`=1 and `req_quad` 1 or 2, both stages run in sequence as in R4.
- R6: With `req_hv`=1, `req_reloc`=1, `req_quad` 0 or 3 and a nonzero `req_lpid`, both stages run in sequence.
- R7: When both stages run, `rsp_psize` is the smaller of the two stage page sizes.
- R8: When both stages run, `rsp_perm` is the bitwise AND of the two stage permission sets. The bit order is [0] read, [1] write, [2] execute.
- R9: A fault from either stage ends the request with `rsp_fault`=1 and `rsp_raddr`=0. After a stage 1 fault, stage 2 is never started.
- R10: `req_ready` goes low in the cycle after a request is accepted and stays low until the response. `rsp_valid` is a single-cycle pulse, and `req_ready` is high again in the cycle after it.
- R11: The access kind (0 read, 1 write, 2 fetch) is passed unchanged to every walker that is started.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_ready | output | 1 | High when a request can be accepted |
| req_hv | input | 1 | Hypervisor state |
| req_reloc | input | 1 | Relocation enabled |
| req_quad | input | 2 | Address quadrant |
| req_lpid | input | LPID_W | Partition ID |
| req_kind | input | 2 | Access kind: 0 read, 1 write, 2 fetch |
| req_addr | input | ADDR_W | Effective address |
| s1_start | output | 1 | Stage 1 start pulse |
| s1_addr | output | ADDR_W | Stage 1 input address |
| s1_kind | output | 2 | Stage 1 access kind |
| s1_done | input | 1 | Stage 1 completion pulse |
| s1_fault | input | 1 | Stage 1 fault, valid with done |
| s1_raddr | input | ADDR_W | Stage 1 output address |
| s1_psize | input | PS_W | Stage 1 page size (log2) |
| s1_perm | input | 3 | Stage 1 permissions |
| s2_start | output | 1 | Stage 2 start pulse |
| s2_addr | output | ADDR_W | Stage 2 input address |
| s2_kind | output | 2 | Stage 2 access kind |
| s2_done | input | 1 | Stage 2 completion pulse |
| s2_fault | input | 1 | Stage 2 fault, valid with done |
| s2_raddr | input | ADDR_W | Stage 2 output address |
| s2_psize | input | PS_W | Stage 2 page size (log2) |
| s2_perm | input | 3 | Stage 2 permissions |
| rsp_valid | output | 1 | Response pulse |
| rsp_fault | output | 1 | Request faulted |
| rsp_raddr | output | ADDR_W | Final real address |
| rsp_psize | output | PS_W | Final page size |
| rsp_perm | output | 3 | Final permissions |

## Verification
A wrong mode decision shows up as an extra or a missing start pulse within the same request. It is seen before the response as a wrong walker start count or a wrong stage 2 input address. A stale first-stage result held across requests shows up in the merged page size or permissions at the next two-stage response. For this reason the bench alternates which stage has the smaller page size. A state machine that fails to return to idle keeps `req_ready` low, and this is caught one cycle after the response pulse.

// File: rtl/xlate_mode_dispatch.sv
module xlate_mode_dispatch #(
  parameter int ADDR_W = 52,
  parameter int LPID_W = 12,
  parameter int PS_W   = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_hv,
  input  logic              req_reloc,
  input  logic [1:0]        req_quad,
  input  logic [LPID_W-1:0] req_lpid,
  input  logic [1:0]        req_kind,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              s1_start,
  output logic [ADDR_W-1:0] s1_addr,
  output logic [1:0]        s1_kind,
  input  logic              s1_done,
  input  logic              s1_fault,
  input  logic [ADDR_W-1:0] s1_raddr,
  input  logic [PS_W-1:0]   s1_psize,
  input  logic [2:0]        s1_perm,
  output logic              s2_start,
  output logic [ADDR_W-1:0] s2_addr,
  output logic [1:0]        s2_kind,
  input  logic              s2_done,
  input  logic              s2_fault,
  input  logic [ADDR_W-1:0] s2_raddr,
  input  logic [PS_W-1:0]   s2_psize,
  input  logic [2:0]        s2_perm,
  output logic              rsp_valid,
  output logic              rsp_fault,
  output logic [ADDR_W-1:0] rsp_raddr,
  output logic [PS_W-1:0]   rsp_psize,
  output logic [2:0]        rsp_perm
);
  typedef enum logic [1:0] {ST_IDLE, ST_S1, ST_S2, ST_RESP} st_t;

  st_t             st;
  logic            want2;
  logic [1:0]      kind_q;
  logic [PS_W-1:0] p1_size;
  logic [2:0]      p1_perm;

  wire accept  = req_valid && (st == ST_IDLE);
  wire mid_q   = (req_quad == 2'd1) || (req_quad == 2'd2);
  wire need1   = req_reloc;
  wire need2   = !req_hv || (req_reloc && (mid_q || (req_lpid != '0)));

  assign req_ready = (st == ST_IDLE);
  assign rsp_valid = (st == ST_RESP);
  assign s1_kind   = kind_q;
  assign s2_kind   = kind_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      want2     <= 1'b0;
      kind_q    <= '0;
      p1_size   <= '1;
      p1_perm   <= '1;
      s1_start  <= 1'b0;
      s2_start  <= 1'b0;
      s1_addr   <= '0;
      s2_addr   <= '0;
      rsp_fault <= 1'b0;
      rsp_raddr <= '0;
      rsp_psize <= '0;
      rsp_perm  <= '0;
    end else begin
      s1_start <= 1'b0;
      s2_start <= 1'b0;
      case (st)
        ST_IDLE: if (accept) begin
          kind_q  <= req_kind;
          want2   <= need2;
          p1_size <= '1;
          p1_perm <= '1;
          if (need1) begin
            s1_addr  <= req_addr;
            s1_start <= 1'b1;
            st       <= ST_S1;
          end else if (need2) begin
            s2_addr  <= req_addr;
            s2_start <= 1'b1;
            st       <= ST_S2;
          end else begin
            rsp_fault <= 1'b0;
            rsp_raddr <= req_addr;
            rsp_psize <= '1;
            rsp_perm  <= '1;
            st        <= ST_RESP;
          end
        end
        ST_S1: if (s1_done) begin
          if (s1_fault) begin
            rsp_fault <= 1'b1;
            rsp_raddr <= '0;
            rsp_psize <= '0;
            rsp_perm  <= '0;
            st        <= ST_RESP;
          end else if (want2) begin
            p1_size  <= s1_psize;
            p1_perm  <= s1_perm;
            s2_addr  <= s1_raddr;
            s2_start <= 1'b1;
            st       <= ST_S2;
          end else begin
            rsp_fault <= 1'b0;
            rsp_raddr <= s1_raddr;
            rsp_psize <= s1_psize;
            rsp_perm  <= s1_perm;
            st        <= ST_RESP;
          end
        end
        ST_S2: if (s2_done) begin
          rsp_fault <= s2_fault;
          rsp_raddr <= s2_fault ? '0 : s2_raddr;
          rsp_psize <= s2_fault ? '0 : ((s2_psize < p1_size) ? s2_psize : p1_size);
          rsp_perm  <= s2_fault ? '0 : (s2_perm & p1_perm);
          st        <= ST_RESP;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

module xlate_mode_dispatch_chk #(
  parameter int ADDR_W = 52
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_hv,
  input logic              req_reloc,
  input logic              s1_start,
  input logic              s2_start,
  input logic              s1_done,
  input logic              s1_fault,
  input logic              rsp_valid,
  input logic              rsp_fault,
  input logic [ADDR_W-1:0] rsp_raddr
);
  // R1
  real_mode_no_walk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_hv && !req_reloc) |=> (!s1_start && !s2_start));
  // R9
  no_s2_after_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_done && s1_fault) |=> !s2_start);
  // R9
  fault_no_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault) |-> (rsp_raddr == '0));
  // R10
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);
  // R10
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> (!rsp_valid && req_ready));
  // R10
  single_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({s1_start, s2_start}));
endmodule

bind xlate_mode_dispatch xlate_mode_dispatch_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_hv(req_hv), .req_reloc(req_reloc), .s1_start(s1_start),
  .s2_start(s2_start), .s1_done(s1_done), .s1_fault(s1_fault),
  .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_raddr(rsp_raddr));

// File: tb/xlate_mode_dispatch_test.sv
`timescale 1ns/1ps
module xlate_mode_dispatch_test;
  localparam int AW = 52, LW = 12, PW = 6;
  localparam logic [AW-1:0] X1 = 52'h0_00A5_0000_1000;
  localparam logic [AW-1:0] X2 = 52'h3_C000_0000_0000;

  logic clk = 0, rst_n = 0;
  always #2.5 clk = ~clk;

  logic req_valid = 0, req_hv = 0, req_reloc = 0;
  logic [1:0] req_quad = 0, req_kind = 0;
  logic [LW-1:0] req_lpid = 0;
  logic [AW-1:0] req_addr = 0;
  logic req_ready, s1_start, s2_start, rsp_valid, rsp_fault;
  logic [AW-1:0] s1_addr, s2_addr, rsp_raddr;
  logic [1:0] s1_kind, s2_kind;
  logic [PW-1:0] rsp_psize;
  logic [2:0] rsp_perm;
  logic s1_done = 0, s2_done = 0;
  logic [AW-1:0] s1_raddr = 0, s2_raddr = 0;
  logic f1 = 0, f2 = 0;
  logic [PW-1:0] ps1 = 12, ps2 = 21;
  logic [2:0] pm1 = 3'b111, pm2 = 3'b111;

  int s1_cnt = 0, s2_cnt = 0, s1_wait = 0, s2_wait = 0;
  logic [AW-1:0] s1_seen = 0, s2_seen = 0;
  logic [1:0] k1_seen = 0, k2_seen = 0;
  int checks = 0, errors = 0;

  xlate_mode_dispatch #(.ADDR_W(AW), .LPID_W(LW), .PS_W(PW)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_hv(req_hv), .req_reloc(req_reloc), .req_quad(req_quad),
    .req_lpid(req_lpid), .req_kind(req_kind), .req_addr(req_addr),
    .s1_start(s1_start), .s1_addr(s1_addr), .s1_kind(s1_kind),
    .s1_done(s1_done), .s1_fault(f1), .s1_raddr(s1_raddr),
    .s1_psize(ps1), .s1_perm(pm1),
    .s2_start(s2_start), .s2_addr(s2_addr), .s2_kind(s2_kind),
    .s2_done(s2_done), .s2_fault(f2), .s2_raddr(s2_raddr),
    .s2_psize(ps2), .s2_perm(pm2),
    .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_raddr(rsp_raddr),
    .rsp_psize(rsp_psize), .rsp_perm(rsp_perm));

  always @(posedge clk) begin
    s1_done <= 0;
    if (s1_start) begin
      s1_cnt <= s1_cnt + 1; s1_seen <= s1_addr; k1_seen <= s1_kind; s1_wait <= 3;
    end else if (s1_wait != 0) begin
      s1_wait <= s1_wait - 1;
      if (s1_wait == 1) begin s1_done <= 1; s1_raddr <= s1_seen ^ X1; end
    end
  end

  always @(posedge clk) begin
    s2_done <= 0;
    if (s2_start) begin
      s2_cnt <= s2_cnt + 1; s2_seen <= s2_addr; k2_seen <= s2_kind; s2_wait <= 2;
    end else if (s2_wait != 0) begin
      s2_wait <= s2_wait - 1;
      if (s2_wait == 1) begin s2_done <= 1; s2_raddr <= s2_seen ^ X2; end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic hv, input logic rl, input logic [1:0] q,
                       input logic [LW-1:0] lp, input logic [1:0] k, input logic [AW-1:0] a);
    int n = 0;
    @(negedge clk);
    req_valid = 1; req_hv = hv; req_reloc = rl; req_quad = q;
    req_lpid = lp; req_kind = k; req_addr = a;
    @(negedge clk);
    req_valid = 0;
    chk(!req_ready, "R10 ready low after accept", 64'(req_ready), 64'd0);
    while (!rsp_valid && n < 100) begin @(negedge clk); n++; end
  endtask

  task automatic after_rsp();
    @(negedge clk);
    chk(!rsp_valid && req_ready, "R10 pulse ends and ready returns",
        64'({rsp_valid, req_ready}), 64'b01);
  endtask

  task automatic t_reset();
    chk(req_ready && !rsp_valid && !s1_start && !s2_start, "R10 reset state",
        64'({req_ready, rsp_valid, s1_start, s2_start}), 64'b1000);
  endtask

  task automatic t_hv_real();
    int c1 = s1_cnt, c2 = s2_cnt;
    issue(1, 0, 2'd1, 12'h5, 2'd0, 52'h1_2345_6789_ABCD);
    chk(rsp_valid && !rsp_fault && rsp_raddr == 52'h1_2345_6789_ABCD, "R1 address passthrough",
        64'(rsp_raddr), 64'h1_2345_6789_ABCD);
    chk(rsp_psize == '1 && rsp_perm == 3'b111, "R1 size/perm",
        64'({rsp_psize, rsp_perm}), 64'({6'h3F, 3'b111}));
    chk(s1_cnt == c1 && s2_cnt == c2, "R1 no walker", 64'(s1_cnt - c1 + s2_cnt - c2), 64'd0);
    after_rsp();
  endtask

  task automatic t_hv_q(input logic [1:0] q);
    int c1 = s1_cnt, c2 = s2_cnt;
    logic [AW-1:0] a = 52'h0_0000_4000_2000 + 52'(q);
    ps1 = 16; pm1 = 3'b101;
    issue(1, 1, q, 12'h0, 2'd2, a);
    chk(rsp_raddr == (a ^ X1) && !rsp_fault, "R2 stage1 address", 64'(rsp_raddr), 64'(a ^ X1));
    chk(rsp_psize == 16 && rsp_perm == 3'b101, "R2 stage1 size/perm",
        64'({rsp_psize, rsp_perm}), 64'({6'd16, 3'b101}));
    chk(s1_cnt == c1 + 1 && s2_cnt == c2 && s1_seen == a, "R2 stage1 only",
        64'({s1_cnt - c1, s2_cnt - c2}), 64'h1_00000000);
    chk(k1_seen == 2'd2, "R11 fetch kind to stage1", 64'(k1_seen), 64'd2);
    after_rsp();
  endtask

  task automatic t_guest_real();
    int c1 = s1_cnt, c2 = s2_cnt;
    logic [AW-1:0] a = 52'h0_0000_0007_7000;
    ps2 = 24; pm2 = 3'b011;
    issue(0, 0, 2'd0, 12'h3, 2'd1, a);
    chk(s2_seen == a && s2_cnt == c2 + 1 && s1_cnt == c1, "R3 stage2 fed with input",
        64'(s2_seen), 64'(a));
    chk(rsp_raddr == (a ^ X2) && rsp_psize == 24 && rsp_perm == 3'b011, "R3 stage2 result",
        64'(rsp_raddr), 64'(a ^ X2));
    chk(k2_seen == 2'd1, "R11 write kind to stage2", 64'(k2_seen), 64'd1);
    after_rsp();
  endtask

  task automatic t_both(input logic hv, input logic [1:0] q, input logic [LW-1:0] lp,
                        input logic [PW-1:0] a1, input logic [PW-1:0] a2,
                        input logic [2:0] m1, input logic [2:0] m2, input string tag);
    int c1 = s1_cnt, c2 = s2_cnt;
    logic [AW-1:0] a = 52'h0_0123_0000_8000;
    logic [PW-1:0] mn = (a1 < a2) ? a1 : a2;
    ps1 = a1; ps2 = a2; pm1 = m1; pm2 = m2;
    issue(hv, 1, q, lp, 2'd0, a);
    chk(s1_cnt == c1 + 1 && s2_cnt == c2 + 1, {tag, " both stages"},
        64'({s1_cnt - c1, s2_cnt - c2}), 64'h1_00000001);
    chk(s2_seen == (a ^ X1), {tag, " stage2 fed by stage1"}, 64'(s2_seen), 64'(a ^ X1));
    chk(rsp_raddr == (a ^ X1 ^ X2) && !rsp_fault, {tag, " final address"},
        64'(rsp_raddr), 64'(a ^ X1 ^ X2));
    chk(rsp_psize == mn, "R7 minimum page size", 64'(rsp_psize), 64'(mn));
    chk(rsp_perm == (m1 & m2), "R8 permission intersection", 64'(rsp_perm), 64'(m1 & m2));
    after_rsp();
  endtask

  task automatic t_fault(input bit in_s1);
    int c2 = s2_cnt;
    f1 = in_s1; f2 = !in_s1;
    issue(0, 1, 2'd0, 12'h1, 2'd0, 52'h0_0000_0000_F000);
    chk(rsp_fault && rsp_raddr == '0, "R9 fault ends request",
        64'({rsp_fault, rsp_raddr}), 64'({1'b1, 52'd0}));
    if (in_s1) chk(s2_cnt == c2, "R9 no stage2 after stage1 fault", 64'(s2_cnt - c2), 64'd0);
    f1 = 0; f2 = 0;
    after_rsp();
  endtask

  bit finished = 0;
  initial begin
    #(200000 * 5);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_hv_real();
    t_hv_q(2'd0);
    t_hv_q(2'd3);
    t_guest_real();
    t_both(0, 2'd0, 12'h0, 12, 21, 3'b111, 3'b101, "R4");
    t_both(1, 2'd1, 12'h0, 30, 16, 3'b011, 3'b110, "R5");
    t_both(1, 2'd2, 12'h0, 21, 21, 3'b101, 3'b001, "R5");
    t_both(1, 2'd3, 12'h7, 16, 12, 3'b110, 3'b111, "R6");
    t_fault(1);
    t_fault(0);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule